// File: doc/BRIEF.md
# System Watchdog Timer

A countdown watchdog controlled through two 32-bit registers on a simple write/read port: a control word and a reload word. Software stores a reload value, then writes the control word with the trigger bit set, which loads the down-counter and restarts the time base. While the run bit is set and the enable strap allows it, the counter steps down once per tick of a selectable unit (1 s, 100 ms or 10 ms), derived from a parameterised input clock frequency.

When the count runs out, the block latches a fired status, stops itself and raises a one-clock request on one of two outputs: a system reset request or a power-off request, picked by an action bit. It then stays stopped until software triggers and runs it again. A strap input can hold the whole timer off; its state reads back as a read-only bit. Servicing the watchdog means writing the trigger bit again before expiry.

Top module: `sys_watchdog`

## Requirements
- R1: After `rst`, the control word reads as 0 apart from bit 3 (which mirrors `strap_dis`), the reload word reads 0, and both request outputs are low.
- R2: Control word layout (`reg_sel`=0): bit 0 run (read-write, 1 = running), bit 1 fired status, bit 2 action (read-write, 0 = reset request, 1 = power-off request), bit 3 strap state (read-only, 1 = disabled), bit 7 trigger (write-only, always reads 0); bits 4 to 6 and 8 to 31 read 0 and ignore writes.
- R3: The reload word (`reg_sel`=1) keeps bits 15:0 of a write and reads 0 in bits 31:16; a value above the count limit is stored as the limit, where the limit is `MAX_CNT` forced into the range 511 to 65535.
- R4: A control write with bit 7 set loads the counter from the reload word and restarts the current unit, also while running; a reload of 0 expires at the first tick.
- R5: The tick period is `CLK_HZ` clocks for unit code 0, `CLK_HZ/10` for code 1 and `CLK_HZ/100` for code 2; a request pulse appears exactly `period * reload` clocks after the control write that triggers and runs the counter.
- R6: Unit code 3 is rejected: no tick occurs and the counter holds until a supported code is applied, after which a full unit is counted.
- R7: While `strap_dis` is 1, control bit 3 reads 1 and the counter does not move; after it drops, counting resumes with a full unit.
- R8: At expiry the fired bit becomes 1, the run bit becomes 0, and exactly one of `rst_req` (action 0) or `poff_req` (action 1) is high for one clock.
- R9: Writing 1 to control bit 1 clears the fired bit; writing 0 leaves it unchanged.
- R10: Clearing the run bit freezes the remaining count; setting it again continues from that count with a fresh unit.
- R11: After expiry no further request occurs until software triggers and runs the counter again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `CLK_HZ` |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control word, 1 = reload word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected word |
| unit_code | input | 2 | Tick unit: 0 = 1 s, 1 = 100 ms, 2 = 10 ms, 3 = rejected |
| strap_dis | input | 1 | Strap: 1 holds the watchdog off |
| rst_req | output | 1 | One-clock system reset request |
| poff_req | output | 1 | One-clock power-off request |

## Verification
The bench aims at the exact expiry cycle in each unit, so a prescaler off by one clock or a counter that fires one tick early or late shows as a timing mismatch in the scoreboard. It retriggers mid-count, pauses and resumes, and holds the timer with the strap and with the rejected unit code; a design that kept a partial unit, ignored the hold, or did not reload on the trigger would fire at the wrong cycle or fire when none was expected. It also probes the fired bit's write-one-to-clear rule, the clamp on oversized reload values, and the absence of repeat pulses after expiry, which a design that left the run bit set would produce.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_W = 32;
    localparam int CNT_W = 16;

    // Control word bit positions (software decodes these)
    localparam int B_RUN   = 0;
    localparam int B_FIRED = 1;
    localparam int B_ACT   = 2;
    localparam int B_STRAP = 3;
    localparam int B_TRIG  = 7;

    typedef enum logic {
        ACT_RESET    = 1'b0,
        ACT_POWEROFF = 1'b1
    } action_e;

    typedef struct packed {
        action_e action;
        logic    fired;
        logic    run;
    } ctrl_t;

    // Clocks per tick for a unit code; 0 marks a rejected code
    function automatic int unsigned unit_div(input logic [1:0] code,
                                             input int unsigned hz);
        case (code)
            2'd0:    return hz;
            2'd1:    return hz / 10;
            2'd2:    return hz / 100;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned count_limit(input int unsigned m);
        if (m < 511)   return 511;
        if (m > 65535) return 65535;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_word(input ctrl_t c,
                                                   input logic strap);
        logic [REG_W-1:0] v;
        v          = '0;
        v[B_RUN]   = c.run;
        v[B_FIRED] = c.fired;
        v[B_ACT]   = c.action;
        v[B_STRAP] = strap;
        return v;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned MAX_CNT = 4095
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             strap_dis,
    input  logic             expire,
    output logic [REG_W-1:0] rdata,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             load
);

    localparam int unsigned    LIMIT   = count_limit(MAX_CNT);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    logic wr_ctrl, wr_cnt;
    logic [CNT_W-1:0] wr_val;
    logic unused_hi;

    assign wr_ctrl   = wr_en && !reg_sel;
    assign wr_cnt    = wr_en &&  reg_sel;
    assign wr_val    = wdata[CNT_W-1:0];
    assign load      = wr_ctrl && wdata[B_TRIG];
    assign unused_hi = ^wdata[REG_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '{action: ACT_RESET, fired: 1'b0, run: 1'b0};
            reload_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run    <= wdata[B_RUN];
                ctrl_q.action <= action_e'(wdata[B_ACT]);
                if (wdata[B_FIRED]) ctrl_q.fired <= 1'b0;
            end
            // expiry wins over a same-cycle software write
            if (expire) begin
                ctrl_q.run   <= 1'b0;
                ctrl_q.fired <= 1'b1;
            end
            if (wr_cnt)
                reload_q <= (wr_val > LIMIT_V) ? LIMIT_V : wr_val;
        end
    end

    always_comb begin
        if (reg_sel) rdata = {{(REG_W-CNT_W){1'b0}}, reload_q};
        else         rdata = ctrl_word(ctrl_q, strap_dis);
    end

    // R3: stored reload never exceeds the limit
    a_r3_reload_capped: assert property (@(posedge clk) disable iff (rst)
        reload_q <= LIMIT_V);

    // R9: a write of 0 to the fired bit keeps it set
    a_r9_zero_keeps_fired: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wdata[B_FIRED] && ctrl_q.fired) |=> ctrl_q.fired);

    // R8: expiry stops the timer and records it
    a_r8_expire_stops: assert property (@(posedge clk) disable iff (rst)
        expire |=> (!ctrl_q.run && ctrl_q.fired));

endmodule

// File: rtl/wdt_tick.sv
module wdt_tick
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000,
    parameter int          PRE_W  = 27
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic [1:0] unit_code,
    input  logic       restart,
    output logic       tick
);

    logic [PRE_W-1:0] div, pre_q;
    logic             active, at_end;

    assign div    = PRE_W'(unit_div(unit_code, CLK_HZ));
    assign active = run_en && (div != '0);
    // >= so a unit change to a shorter period cannot overshoot the wrap
    assign at_end = (pre_q >= div - PRE_W'(1));
    assign tick   = active && at_end;

    always_ff @(posedge clk) begin
        if (rst || restart || !active || at_end) pre_q <= '0;
        else                                      pre_q <= pre_q + PRE_W'(1);
    end

    // R5: every tick starts a whole new unit
    a_r5_tick_restarts_unit: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pre_q == '0));

endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    assign expire = tick && !load && (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (load)   cnt_q <= reload;
        else if (expire) cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q - CNT_W'(1);
    end

    // R4: a trigger loads the reload value
    a_r4_trigger_loads: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(reload)));

endmodule

// File: rtl/sys_watchdog.sv
module sys_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned MAX_CNT = 4095
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        reg_sel,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [1:0]  unit_code,
    input  logic        strap_dis,
    output logic        rst_req,
    output logic        poff_req
);

    localparam int PRE_W = $clog2(CLK_HZ + 1);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q, cnt_q;
    logic             load, tick, expire;

    wdt_regs #(.MAX_CNT(MAX_CNT)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel),
        .wdata(wdata), .strap_dis(strap_dis), .expire(expire),
        .rdata(rdata), .ctrl_q(ctrl_q), .reload_q(reload_q), .load(load)
    );

    wdt_tick #(.CLK_HZ(CLK_HZ), .PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst(rst), .run_en(ctrl_q.run && !strap_dis),
        .unit_code(unit_code), .restart(load), .tick(tick)
    );

    wdt_count u_count (
        .clk(clk), .rst(rst), .load(load), .reload(reload_q),
        .tick(tick), .cnt_q(cnt_q), .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req  <= 1'b0;
            poff_req <= 1'b0;
        end else begin
            rst_req  <= expire && (ctrl_q.action == ACT_RESET);
            poff_req <= expire && (ctrl_q.action == ACT_POWEROFF);
        end
    end

    // R8: never both requests, each lasts one clock
    a_r8_one_action: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && poff_req));
    a_r8_rst_one_clock: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);
    a_r8_poff_one_clock: assert property (@(posedge clk) disable iff (rst)
        poff_req |=> !poff_req);

    // R11: a request is only seen with the timer stopped and fired latched
    a_r11_stopped_after: assert property (@(posedge clk) disable iff (rst)
        (rst_req || poff_req) |-> (!ctrl_q.run && ctrl_q.fired));

    // R7: strap holds the time base
    a_r7_no_tick_when_disabled: assert property (@(posedge clk) disable iff (rst)
        strap_dis |-> !tick);

    // R6: rejected unit code produces no tick
    a_r6_bad_unit_no_tick: assert property (@(posedge clk) disable iff (rst)
        (unit_code == 2'd3) |-> !tick);

endmodule

// File: tb/sys_watchdog_bench.sv
module sys_watchdog_bench;

    localparam int unsigned HZ  = 1000;
    localparam int unsigned MAX = 600;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  unit_code = 2'd2;
    logic        strap_dis = 1'b0;
    logic        rst_req, poff_req;

    sys_watchdog #(.CLK_HZ(HZ), .MAX_CNT(MAX)) u_sys_watchdog (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .unit_code(unit_code),
        .strap_dis(strap_dis), .rst_req(rst_req), .poff_req(poff_req)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit    poff;
        int    cyc;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   npulse = 0;
    int   t;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop expected pulses as they appear
    always @(negedge clk) begin
        if (!rst && (rst_req || poff_req)) begin
            exp_t e;
            npulse++;
            n_cmp++;
            if (rst_req && poff_req) begin
                n_bad++;
                $display("FAIL R8 both requests high at cycle %0d (expected one)", cyc);
            end else if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R11 unexpected pulse poff=%0b at cycle %0d (expected none)",
                         poff_req, cyc);
            end else begin
                e = sb.pop_front();
                if (e.poff != poff_req || e.cyc != cyc) begin
                    n_bad++;
                    $display("FAIL %s pulse poff=%0b cycle %0d (expected poff=%0b cycle %0d)",
                             e.tag, poff_req, cyc, e.poff, e.cyc);
                end
            end
        end
    end

    task automatic expect_pulse(input bit poff, input int at, input string tag);
        exp_t e;
        e.poff = poff; e.cyc = at; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        t = cyc;
    endtask

    task automatic chk(input logic sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_sel = sel;
        #1;
        n_cmp++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s rdata=%h (expected %h)", tag, rdata, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s value=%0d (expected %0d)", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(1'b0, 32'h0, "R1 ctrl after reset");
        chk(1'b1, 32'h0, "R1 reload after reset");
        n_cmp++;
        if (rst_req || poff_req) begin
            n_bad++;
            $display("FAIL R1 requests high after reset (expected low)");
        end

        // R2 layout: reserved bits ignored, action read-write
        wr(1'b0, 32'hFFFF_FF74);
        chk(1'b0, 32'h0000_0004, "R2 reserved bits read 0");
        wr(1'b0, 32'h0);
        chk(1'b0, 32'h0, "R2 action cleared");

        // R3 reload width and clamp
        wr(1'b1, 32'hABCD_0005);
        chk(1'b1, 32'h5, "R3 upper bits dropped");
        wr(1'b1, 32'd5000);
        chk(1'b1, MAX, "R3 clamp to limit");
        wr(1'b1, 32'h0000_FFFF);
        chk(1'b1, MAX, "R3 clamp max value");

        // R5/R8 10 ms unit, reset action
        unit_code = 2'd2;
        wr(1'b1, 32'd5);
        wr(1'b0, 32'h81);
        expect_pulse(1'b0, t + 50, "R5 unit code 2");
        idle(60);
        chk(1'b0, 32'h2, "R8 fired set, run cleared");

        // R9 write-one-to-clear
        wr(1'b0, 32'h0);
        chk(1'b0, 32'h2, "R9 write 0 keeps fired");
        wr(1'b0, 32'h2);
        chk(1'b0, 32'h0, "R9 write 1 clears fired");

        // R11 no further pulse
        idle(150);
        chk_int(npulse, 1, "R11 stays stopped");

        // R5/R8 100 ms unit, power-off action
        unit_code = 2'd1;
        wr(1'b1, 32'd3);
        wr(1'b0, 32'h85);
        expect_pulse(1'b1, t + 300, "R8 power-off at code 1");
        idle(310);
        chk(1'b0, 32'h6, "R8 fired with action kept");
        wr(1'b0, 32'h6);
        chk(1'b0, 32'h4, "R9 clear keeps action");

        // R5 1 s unit
        unit_code = 2'd0;
        wr(1'b1, 32'd2);
        wr(1'b0, 32'h81);
        expect_pulse(1'b0, t + 2000, "R5 unit code 0");
        idle(2010);
        wr(1'b0, 32'h2);

        // R4 reload of 0 expires at first tick
        unit_code = 2'd2;
        wr(1'b1, 32'd0);
        wr(1'b0, 32'h81);
        expect_pulse(1'b0, t + 10, "R4 zero reload");
        idle(20);
        wr(1'b0, 32'h2);

        // R7 strap hold
        @(negedge clk);
        strap_dis = 1'b1;
        wr(1'b1, 32'd4);
        wr(1'b0, 32'h81);
        chk(1'b0, 32'h9, "R7 strap bit reads 1");
        idle(100);
        chk_int(npulse, 4, "R7 no count while disabled");
        @(negedge clk);
        strap_dis = 1'b0;
        expect_pulse(1'b0, cyc + 40, "R7 resume after strap");
        idle(50);
        wr(1'b0, 32'h2);

        // R6 rejected unit code
        unit_code = 2'd3;
        wr(1'b1, 32'd2);
        wr(1'b0, 32'h81);
        idle(200);
        chk_int(npulse, 5, "R6 code 3 frozen");
        @(negedge clk);
        unit_code = 2'd2;
        expect_pulse(1'b0, cyc + 20, "R6 resume after valid code");
        idle(30);
        wr(1'b0, 32'h2);

        // R10 pause and resume
        wr(1'b1, 32'd5);
        wr(1'b0, 32'h81);
        idle(13);
        wr(1'b0, 32'h0);
        idle(100);
        chk_int(npulse, 6, "R10 paused holds");
        wr(1'b0, 32'h1);
        expect_pulse(1'b0, t + 40, "R10 resume keeps count");
        idle(50);
        wr(1'b0, 32'h2);

        // R4 retrigger while running
        wr(1'b0, 32'h81);
        idle(25);
        wr(1'b0, 32'h81);
        expect_pulse(1'b0, t + 50, "R4 retrigger reloads");
        idle(70);

        chk_int(sb.size(), 0, "R11 all expected pulses seen");
        chk_int(npulse, 8, "R11 pulse total");

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired (expected completion)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule